// File: doc/BRIEF.md
# Warp Load Coalescer

This unit takes the byte addresses of one warp's load, one address per lane with a per-lane active flag, and turns them into the fewest aligned memory segment requests. Every active lane's address is rounded down to the base of its segment. All lanes whose bases agree are served by a single request. The segment size comes from a mode bit captured with the warp: 128 bytes when the load may be cached at the first level, and 32 bytes when it is cached only at the second level. The small size keeps wasted bytes low in each burst that the memory channel returns.

Requests leave one at a time on a valid/ready port. The next segment is always the one needed by the lowest-numbered active lane that is still unserved. When the last request has been taken, the unit raises `done` for one cycle. At that point it presents, for every lane, the position of its segment in the issue order, so returned data can be routed to lanes. It also presents the total number of requests. These results hold until the next warp is accepted. A new warp is accepted only from the idle state.

The controller has three states:
- `ST_IDLE` waits for a warp and is the only state with `warp_ready` high.
- `ST_ISSUE` presents requests.
- `ST_DONE` raises `done` for one cycle.

It has four transitions:
- **accept-work**: `ST_IDLE` to `ST_ISSUE`, taken when an accepted warp has at least one active lane.
- **accept-empty**: `ST_IDLE` to `ST_DONE`, taken when an accepted warp has no active lane.
- **last-issue**: `ST_ISSUE` to `ST_DONE`, taken on the handshake that serves the final pending lanes.
- **release**: `ST_DONE` to `ST_IDLE`, taken unconditionally.

Top module: `wc_coalescer`

## Requirements
- R1: Every request address is the lane address with its low 7 bits cleared when the captured mode bit `warp_cached` is 1, and with its low 5 bits cleared when it is 0.
- R2: Lanes whose aligned bases are equal share one request, and each distinct base among active lanes is requested exactly once.
- R3: Requests are issued in increasing order of the lowest active lane index that maps to each segment.
- R4: Lanes with a 0 in `warp_lane_valid` cause no request, and their field in `lane_seg` reads 0.
- R5: A warp with no active lane raises `done` in the cycle after its acceptance edge, with `seg_count` equal to 0 and no request.
- R6: While `req_valid` is high and `req_ready` is low, `req_valid` stays high and `req_addr` does not change.
- R7: `warp_ready` is low from the acceptance edge until `done` has been high for one cycle. It is high again in the following cycle. Inputs offered while the unit is busy are not captured.
- R8: While `done` is high and until the next acceptance, field i of `lane_seg` (bits [i*IW +: IW], where IW = log2(LANES)) holds the 0-based issue position of lane i's segment.
- R9: `seg_count` equals the number of requests issued for the warp and is valid while `done` is high.
- R10: After reset, `warp_ready` is 1, and `req_valid`, `done` and `seg_count` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| warp_valid | input | 1 | A warp is offered |
| warp_ready | output | 1 | Unit is idle and takes the offered warp |
| warp_cached | input | 1 | 1 selects 128-byte segments, 0 selects 32-byte segments |
| warp_lane_valid | input | LANES | Per-lane active flag |
| warp_addr | input | LANES*AW | Lane byte addresses, lane i in bits [i*AW +: AW] |
| req_valid | output | 1 | A segment request is presented |
| req_ready | input | 1 | Downstream takes the request |
| req_addr | output | AW | Segment base address |
| done | output | 1 | One-cycle completion flag |
| lane_seg | output | LANES*log2(LANES) | Per-lane issue position of the lane's segment |
| seg_count | output | log2(LANES+1) | Number of requests issued for the warp |

## Verification
Two events can fall on the same clock edge. The handshake that serves the final pending lanes also moves the unit to completion. Meanwhile, a new warp may already be waiting on the input port with `warp_valid` high. The bench provokes this by holding `warp_valid` high with different data for the whole busy period, while `req_ready` follows patterns that range from always high to mostly stalled. It then judges the request stream, `lane_seg` and `seg_count` against a model that uses only the first warp's addresses. Sweeps over strides, all lane masks, both segment sizes and random clustered addresses cover merging, ordering and the empty warp.

// File: rtl/wc_pkg.sv
package wc_pkg;
    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_ISSUE = 2'd1,
        ST_DONE  = 2'd2
    } wc_state_e;
endpackage

// File: rtl/wc_lane_align.sv
module wc_lane_align #(
    parameter int LANES     = 32,
    parameter int AW        = 32,
    parameter int BIG_LG2   = 7,
    parameter int SMALL_LG2 = 5
) (
    input  logic              big,
    input  logic [LANES*AW-1:0] addr_in,
    output logic [LANES*AW-1:0] base_out
);
    localparam logic [AW-1:0] KEEP_BIG   = {AW{1'b1}} << BIG_LG2;
    localparam logic [AW-1:0] KEEP_SMALL = {AW{1'b1}} << SMALL_LG2;

    logic [AW-1:0] keep;
    assign keep = big ? KEEP_BIG : KEEP_SMALL;

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        assign base_out[g*AW +: AW] = addr_in[g*AW +: AW] & keep;
    end
endmodule

// File: rtl/wc_leader_pick.sv
module wc_leader_pick #(
    parameter int LANES = 32,
    parameter int AW    = 32,
    localparam int IW   = $clog2(LANES)
) (
    input  logic [LANES-1:0]    pending,
    input  logic [LANES*AW-1:0] base_in,
    output logic [IW-1:0]       leader,
    output logic [AW-1:0]       leader_base,
    output logic [LANES-1:0]    match
);
    always_comb begin
        leader = '0;
        for (int i = LANES - 1; i >= 0; i--) begin
            if (pending[i]) leader = IW'(i);
        end
    end

    assign leader_base = base_in[leader*AW +: AW];

    for (genvar g = 0; g < LANES; g++) begin : g_cmp
        assign match[g] = pending[g] && (base_in[g*AW +: AW] == leader_base);
    end
endmodule

// File: rtl/wc_coalescer.sv
module wc_coalescer
    import wc_pkg::*;
#(
    parameter int LANES     = 32,
    parameter int AW        = 32,
    parameter int BIG_LG2   = 7,
    parameter int SMALL_LG2 = 5
) (
    input  logic                            clk,
    input  logic                            rst_n,
    input  logic                            warp_valid,
    output logic                            warp_ready,
    input  logic                            warp_cached,
    input  logic [LANES-1:0]                warp_lane_valid,
    input  logic [LANES*AW-1:0]             warp_addr,
    output logic                            req_valid,
    input  logic                            req_ready,
    output logic [AW-1:0]                   req_addr,
    output logic                            done,
    output logic [LANES*$clog2(LANES)-1:0]  lane_seg,
    output logic [$clog2(LANES+1)-1:0]      seg_count
);
    localparam int IW = $clog2(LANES);
    localparam int CW = $clog2(LANES + 1);

    wc_state_e          state_q, state_d;
    logic [LANES-1:0]   pending_q;
    logic [LANES*AW-1:0] base_q;
    logic [LANES*AW-1:0] base_in;
    logic               big_q;
    logic [LANES*IW-1:0] seg_q;
    logic [CW-1:0]      cnt_q;

    logic [IW-1:0]      leader;
    logic [AW-1:0]      leader_base;
    logic [LANES-1:0]   match;
    logic               accept;
    logic               hs;

    wc_lane_align #(
        .LANES(LANES), .AW(AW), .BIG_LG2(BIG_LG2), .SMALL_LG2(SMALL_LG2)
    ) u_align (
        .big      (warp_cached),
        .addr_in  (warp_addr),
        .base_out (base_in)
    );

    wc_leader_pick #(
        .LANES(LANES), .AW(AW)
    ) u_pick (
        .pending     (pending_q),
        .base_in     (base_q),
        .leader      (leader),
        .leader_base (leader_base),
        .match       (match)
    );

    assign accept = warp_valid && (state_q == ST_IDLE);
    assign hs     = req_ready && (state_q == ST_ISSUE);

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // transitions
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (warp_valid)
                    state_d = (warp_lane_valid == '0) ? ST_DONE : ST_ISSUE;
            end
            ST_ISSUE: begin
                if (req_ready && ((pending_q & ~match) == '0))
                    state_d = ST_DONE;
            end
            ST_DONE:  state_d = ST_IDLE;
            default:  state_d = ST_IDLE;
        endcase
    end

    // outputs
    always_comb begin
        warp_ready = 1'b0;
        req_valid  = 1'b0;
        done       = 1'b0;
        unique case (state_q)
            ST_IDLE:  warp_ready = 1'b1;
            ST_ISSUE: req_valid  = 1'b1;
            ST_DONE:  done       = 1'b1;
            default:  ;
        endcase
        req_addr  = leader_base;
        lane_seg  = seg_q;
        seg_count = cnt_q;
    end

    // warp capture and per-issue bookkeeping
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pending_q <= '0;
            base_q    <= '0;
            big_q     <= 1'b0;
            seg_q     <= '0;
            cnt_q     <= '0;
        end else if (accept) begin
            pending_q <= warp_lane_valid;
            base_q    <= base_in;
            big_q     <= warp_cached;
            seg_q     <= '0;
            cnt_q     <= '0;
        end else if (hs) begin
            pending_q <= pending_q & ~match;
            cnt_q     <= cnt_q + CW'(1);
            for (int i = 0; i < LANES; i++) begin
                if (match[i]) seg_q[i*IW +: IW] <= cnt_q[IW-1:0];
            end
        end
    end

    // assertions
    p_aligned_r1: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |-> (big_q ? (req_addr[BIG_LG2-1:0] == '0)
                             : (req_addr[SMALL_LG2-1:0] == '0)));

    p_shrink_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready) |=> ($countones(pending_q) < $past($countones(pending_q))));

    p_empty_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (warp_valid && warp_ready && (warp_lane_valid == '0)) |=> (done && (seg_count == '0)));

    p_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !req_ready) |=> (req_valid && $stable(req_addr)));

    p_release_r7: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> (warp_ready && !done));

    p_count_r9: assert property (@(posedge clk) disable iff (!rst_n)
        seg_count <= CW'(LANES));
endmodule

// File: tb/sim_wc_coalescer.sv
`timescale 1ns/1ps
module sim_wc_coalescer;
    localparam int LANES = 8;
    localparam int AW    = 16;
    localparam int IW    = $clog2(LANES);
    localparam int CW    = $clog2(LANES + 1);

    logic                 clk = 1'b0;
    logic                 rst_n = 1'b0;
    logic                 warp_valid = 1'b0;
    logic                 warp_ready;
    logic                 warp_cached = 1'b0;
    logic [LANES-1:0]     warp_lane_valid = '0;
    logic [LANES*AW-1:0]  warp_addr = '0;
    logic                 req_valid;
    logic                 req_ready = 1'b0;
    logic [AW-1:0]        req_addr;
    logic                 done;
    logic [LANES*IW-1:0]  lane_seg;
    logic [CW-1:0]        seg_count;

    int checks = 0;
    int failures = 0;
    bit finished = 1'b0;
    logic [31:0] rng = 32'h1ACE_B00C;
    logic [AW-1:0] tb_addr [LANES];

    always #5 clk = ~clk;

    wc_coalescer #(.LANES(LANES), .AW(AW)) u0 (
        .clk(clk), .rst_n(rst_n),
        .warp_valid(warp_valid), .warp_ready(warp_ready),
        .warp_cached(warp_cached), .warp_lane_valid(warp_lane_valid),
        .warp_addr(warp_addr),
        .req_valid(req_valid), .req_ready(req_ready), .req_addr(req_addr),
        .done(done), .lane_seg(lane_seg), .seg_count(seg_count)
    );

    task automatic chk(input bit ok, input string req, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic step_rng();
        rng = {rng[30:0], rng[31] ^ rng[21] ^ rng[1] ^ rng[0]};
    endtask

    task automatic run_warp(input logic [LANES-1:0] m, input bit big,
                            input bit hold_valid, input int rdy_level);
        logic [AW-1:0] keep;
        logic [AW-1:0] esegs [LANES];
        int eidx [LANES];
        int ecount;
        int k;
        int cyc;
        bit rdy;
        keep = big ? ({AW{1'b1}} << 7) : ({AW{1'b1}} << 5);
        ecount = 0;
        for (int i = 0; i < LANES; i++) begin
            eidx[i] = 0;
            esegs[i] = '0;
        end
        for (int i = 0; i < LANES; i++) begin
            if (m[i]) begin
                logic [AW-1:0] b;
                bit found;
                b = tb_addr[i] & keep;
                found = 1'b0;
                for (int j = 0; j < ecount; j++) begin
                    if (!found && esegs[j] == b) begin
                        found = 1'b1;
                        eidx[i] = j;
                    end
                end
                if (!found) begin
                    esegs[ecount] = b;
                    eidx[i] = ecount;
                    ecount++;
                end
            end
        end

        @(negedge clk);
        chk(warp_ready == 1'b1, "R7 idle ready", warp_ready, 1);
        warp_valid = 1'b1;
        warp_cached = big;
        warp_lane_valid = m;
        for (int i = 0; i < LANES; i++) warp_addr[i*AW +: AW] = tb_addr[i];
        req_ready = 1'b0;
        @(negedge clk);
        if (hold_valid) begin
            for (int i = 0; i < LANES; i++) warp_addr[i*AW +: AW] = ~tb_addr[i];
            warp_lane_valid = '1;
            warp_cached = ~big;
        end else begin
            warp_valid = 1'b0;
        end
        if (ecount == 0)
            chk(done && !req_valid, "R5 empty warp completes next cycle", {done, req_valid}, 2);

        k = 0;
        cyc = 0;
        while (!done && cyc < 400) begin
            chk(warp_ready == 1'b0, "R7 busy not ready", warp_ready, 0);
            if (req_valid) begin
                if (k < ecount)
                    chk(req_addr == esegs[k], "R1 R2 R3 R6 request address", req_addr, esegs[k]);
                else
                    chk(1'b0, "R2 R4 extra request", k, ecount);
            end else begin
                chk(1'b0, "R2 neither request nor done", 0, 1);
            end
            step_rng();
            rdy = (int'(rng[1:0]) >= rdy_level);
            req_ready = rdy;
            @(posedge clk);
            if (rdy && req_valid) k++;
            @(negedge clk);
            cyc++;
        end
        req_ready = 1'b0;
        chk(done == 1'b1, "R2 completion reached", done, 1);
        chk(k == ecount, "R2 request count", k, ecount);
        chk(int'(seg_count) == ecount, "R9 seg_count", seg_count, ecount);
        chk(req_valid == 1'b0, "R5 no request at done", req_valid, 0);
        for (int i = 0; i < LANES; i++) begin
            if (m[i])
                chk(int'(lane_seg[i*IW +: IW]) == eidx[i], "R8 lane_seg active lane",
                    lane_seg[i*IW +: IW], eidx[i]);
            else
                chk(lane_seg[i*IW +: IW] == '0, "R4 inactive lane_seg zero",
                    lane_seg[i*IW +: IW], 0);
        end
        warp_valid = 1'b0;
        @(negedge clk);
        chk(warp_ready && !done, "R7 ready after done", {warp_ready, done}, 2);
        chk(int'(seg_count) == ecount, "R8 results held after done", seg_count, ecount);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            checks++;
            failures++;
            $display("FAIL watchdog expired");
            $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        int strides [10];
        logic [LANES-1:0] masks [5];
        strides = '{0, 1, 4, 8, 16, 32, 48, 64, 128, 200};
        masks = '{8'hFF, 8'h55, 8'h80, 8'h01, 8'h00};
        repeat (3) @(negedge clk);
        chk(warp_ready == 1'b1, "R10 reset warp_ready", warp_ready, 1);
        chk(req_valid == 1'b0, "R10 reset req_valid", req_valid, 0);
        chk(done == 1'b0, "R10 reset done", done, 0);
        chk(seg_count == '0, "R10 reset seg_count", seg_count, 0);
        rst_n = 1'b1;

        // stride sweep, both segment sizes, several lane masks
        for (int s = 0; s < 10; s++) begin
            for (int b = 0; b < 2; b++) begin
                for (int mi = 0; mi < 5; mi++) begin
                    for (int i = 0; i < LANES; i++)
                        tb_addr[i] = AW'(16'h0A40 + i * strides[s]);
                    run_warp(masks[mi], b[0], (s + mi) % 2 == 1, (s + b + mi) % 4);
                end
            end
        end

        // every lane mask, fixed stride
        for (int mm = 0; mm < 256; mm++) begin
            for (int i = 0; i < LANES; i++) tb_addr[i] = AW'(16'h1010 + i * 24);
            run_warp(LANES'(mm), mm[0], mm[1], mm % 3);
        end

        // descending addresses: order follows lane index, not address (R3)
        for (int b = 0; b < 2; b++) begin
            for (int i = 0; i < LANES; i++) tb_addr[i] = AW'(16'h2000 + (LANES - 1 - i) * 40);
            run_warp('1, b[0], 1'b1, 2);
        end

        // clustered random addresses
        for (int w = 0; w < 300; w++) begin
            logic [AW-1:0] base;
            step_rng();
            base = AW'(rng[15:0]);
            for (int i = 0; i < LANES; i++) begin
                step_rng();
                tb_addr[i] = base + AW'(rng[8:0]);
            end
            step_rng();
            run_warp(LANES'(rng[7:0]) | LANES'(rng[9:8] == 2'b00 ? 8'h00 : 8'h81),
                     rng[10], rng[11], int'(rng[13:12]));
        end

        finished = 1'b1;
        $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule